// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block sits in the register file of a classic 8-bit UART. It merges four interrupt sources into one active-high interrupt request, and it keeps a 3-bit identification code that the host reads to learn which source needs service. The four sources are a line-status error event, the receive-data-ready level, the transmit-holding-empty event and the modem-status-change event. A 4-bit enable register gates each source. The host writes it through a qualified write strobe and reads it back as an 8-bit value.

The identification code is held in a register. While the host is reading it, the surrounding bus logic raises a hold input, and the code then stays frozen so that the value read cannot change mid-read. Bit 2 of the code goes to the transmitter, which uses it to block clearing of its empty flag. A build-time parameter replaces the writable enable register with a constant mask when the enables never need to change. Bus address decoding and the logic that produces the source events are outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset, the identification readback is 8'h01, the interrupt output is 0 and the enable readback is 8'h00 (writable variant).
- R2: When the enable write strobe is high at a clock edge, data bits 3..0 are stored in the enable register. Bits 7..4 are ignored, and the enable readback shows the stored value with bits 7..4 reading 0.
- R3: A source counts as pending only when its enable bit is set. Enable bit 0 gates receive-data-ready, bit 1 gates transmit-empty, bit 2 gates line-status and bit 3 gates modem-status.
- R4: Pending sources are ranked highest first as line-status (code 3'b110), receive-data (3'b100), transmit-empty (3'b010) and modem-status (3'b000). The code register loads the code of the highest pending source one clock edge after the inputs are sampled.
- R5: When no source is pending, the code register loads 3'b001.
- R6: The interrupt output is high exactly when bit 0 of the stored identification code is 0.
- R7: The identification readback is 8 bits wide, carries the code in bits 2..0, and bits 7..3 always read 0.
- R8: While the hold input is high, the identification code and the interrupt output keep their values. At the first edge after hold falls, the code again follows the pending sources.
- R9: When the parameter FIXED_EN_MASK is non-zero, its value is the enable mask, enable writes have no effect, and the enable readback shows that mask.
- R10: The transmitter output id_bit2 equals bit 2 of the stored identification code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_wr | input | 1 | Enable-register write strobe, already qualified by bus decode |
| en_wdata | input | 8 | Write data bus; only bits 3..0 are used |
| hold_id | input | 1 | Freezes the identification register while the host reads it |
| src_line | input | 1 | Line-status error event |
| src_rxrdy | input | 1 | Receive data ready level |
| src_thre | input | 1 | Transmit holding register empty event |
| src_modem | input | 1 | Modem status change event |
| en_rdata | output | 8 | Enable register readback, bits 7..4 zero |
| id_rdata | output | 8 | Identification readback, bits 7..3 zero |
| id_bit2 | output | 1 | Bit 2 of the identification code, for the transmitter |
| irq | output | 1 | Interrupt request, active high |

## Verification
The clocked properties assume that every input is a defined 0 or 1 at each rising edge once reset is released. They also assume that hold_id is a plain level, so a held cycle compares cleanly against the cycle before it. The bench drives all inputs to known values from time zero. It changes inputs only on falling edges and samples outputs one falling edge after the rising edge that loads them. It raises hold_id in the same half-cycle as a new source event, which shows that the freeze wins over a pending update.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, identification codes and source indices for the
// UART interrupt identification controller.
// Assumes: exactly four sources; code values are read by host software.
package uart_irq_pkg;

    localparam int NUM_SRC = 4;
    localparam int ID_W    = 3;

    typedef logic [ID_W-1:0] irq_id_t;

    // Identification codes; bit 0 low means an interrupt is pending.
    localparam irq_id_t ID_LINE  = 3'b110;
    localparam irq_id_t ID_RXD   = 3'b100;
    localparam irq_id_t ID_THRE  = 3'b010;
    localparam irq_id_t ID_MODEM = 3'b000;
    localparam irq_id_t ID_NONE  = 3'b001;

    // Position of each source in the enable / pending vectors.
    localparam int SRC_RXD   = 0;
    localparam int SRC_THRE  = 1;
    localparam int SRC_LINE  = 2;
    localparam int SRC_MODEM = 3;

    // Source index held at each priority rank, rank 0 highest.
    function automatic int rank_src(input int rank);
        case (rank)
            0:       return SRC_LINE;
            1:       return SRC_RXD;
            2:       return SRC_THRE;
            default: return SRC_MODEM;
        endcase
    endfunction

    // Identification code reported for a given source index.
    function automatic irq_id_t src_code(input int src);
        case (src)
            SRC_LINE: return ID_LINE;
            SRC_RXD:  return ID_RXD;
            SRC_THRE: return ID_THRE;
            default:  return ID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
// Module: interrupt enable storage. Builds a writable register when
// FIXED_MASK is zero; otherwise drives FIXED_MASK as a constant.
// Assumes: wr is already qualified by address decode; reset is synchronous
// and active low.
module uart_irq_enable #(
    parameter int DATA_W                     = 8,
    parameter int EN_W                       = 4,
    parameter logic [EN_W-1:0] FIXED_MASK    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [EN_W-1:0]   en
);

    localparam int UPPER_W = DATA_W - EN_W;

    generate
        if (FIXED_MASK == '0) begin : g_writable
            logic [EN_W-1:0] en_q;
            logic [UPPER_W-1:0] unused_upper;

            // Load the low data bits on a qualified write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_q <= '0;
                else if (wr)
                    en_q <= wdata[EN_W-1:0];
            end

            assign unused_upper = wdata[DATA_W-1:EN_W];
            assign en           = en_q;

            assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> (en == $past(wdata[EN_W-1:0])));
            assert_hold_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !wr |=> $stable(en));
        end else begin : g_fixed
            logic unused_fixed;

            assign unused_fixed = ^{clk, rst_n, wr, wdata};
            assign en           = FIXED_MASK;
        end
    endgenerate

endmodule

// File: rtl/uart_irq_prio.sv
// Module: combinational priority encoder from gated pending sources to an
// identification code.
// Assumes: pending is already masked by the enables.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pending,
    output irq_id_t      code
);

    // Walk ranks lowest to highest so the highest pending rank wins.
    always_comb begin
        code = ID_NONE;
        for (int r = N - 1; r >= 0; r--) begin
            if (pending[rank_src(r)])
                code = src_code(rank_src(r));
        end
    end

endmodule

// File: rtl/uart_irq_idreg.sv
// Module: identification code register and interrupt flop. Both freeze
// while hold is high.
// Assumes: hold is a level asserted for the duration of a host read.
module uart_irq_idreg
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  irq_id_t next_code,
    output irq_id_t code,
    output logic    irq
);

    irq_id_t code_q;
    logic    irq_q;

    // Capture the encoder result unless a read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= ID_NONE;
            irq_q  <= 1'b0;
        end else if (!hold) begin
            code_q <= next_code;
            irq_q  <= (next_code != ID_NONE);
        end
    end

    assign code = code_q;
    assign irq  = irq_q;

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(code) && $stable(irq)));
    assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !code[0]);
    assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code == ID_LINE) || (code == ID_RXD) || (code == ID_THRE)
        || (code == ID_MODEM) || (code == ID_NONE));

endmodule

// File: rtl/uart_irq_ident.sv
// Module: top of the UART interrupt identification controller. Gates the
// four sources with the enables, encodes by priority and registers the code.
// Assumes: synchronous active-low reset; sources are synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W                        = 8,
    parameter logic [NUM_SRC-1:0] FIXED_EN_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_wdata,
    input  logic              hold_id,
    input  logic              src_line,
    input  logic              src_rxrdy,
    input  logic              src_thre,
    input  logic              src_modem,
    output logic [DATA_W-1:0] en_rdata,
    output logic [DATA_W-1:0] id_rdata,
    output logic              id_bit2,
    output logic              irq
);

    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] pending;
    irq_id_t            next_code;
    irq_id_t            code;

    uart_irq_enable #(
        .DATA_W     (DATA_W),
        .EN_W       (NUM_SRC),
        .FIXED_MASK (FIXED_EN_MASK)
    ) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en    (en)
    );

    // Place each source at its enable bit position.
    always_comb begin
        raw_src            = '0;
        raw_src[SRC_RXD]   = src_rxrdy;
        raw_src[SRC_THRE]  = src_thre;
        raw_src[SRC_LINE]  = src_line;
        raw_src[SRC_MODEM] = src_modem;
    end

    assign pending = raw_src & en;

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .pending (pending),
        .code    (next_code)
    );

    uart_irq_idreg u_idreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_id),
        .next_code (next_code),
        .code      (code),
        .irq       (irq)
    );

    assign en_rdata = {{(DATA_W-NUM_SRC){1'b0}}, en};
    assign id_rdata = {{(DATA_W-ID_W){1'b0}}, code};
    assign id_bit2  = code[2];

    assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_id && pending == '0) |=> (code == ID_NONE));
    assert_line_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_id && pending[SRC_LINE]) |=> (code == ID_LINE));
    assert_gated_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_id && en == '0) |=> !irq);

endmodule

// File: tb/uart_irq_ident_bench.sv
// Directed bench for uart_irq_ident: one task per scenario, each checking
// its own results. Inputs change on falling edges, outputs sampled there.
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic       hold_id = 1'b0;
    logic       src_line = 1'b0;
    logic       src_rxrdy = 1'b0;
    logic       src_thre = 1'b0;
    logic       src_modem = 1'b0;
    logic [7:0] en_rdata, id_rdata, en_rdata_f, id_rdata_f;
    logic       id_bit2, irq, id_bit2_f, irq_f;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .hold_id(hold_id), .src_line(src_line), .src_rxrdy(src_rxrdy),
        .src_thre(src_thre), .src_modem(src_modem), .en_rdata(en_rdata),
        .id_rdata(id_rdata), .id_bit2(id_bit2), .irq(irq)
    );

    uart_irq_ident #(.FIXED_EN_MASK(4'b0100)) u_uart_irq_ident_fixed (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .hold_id(hold_id), .src_line(src_line), .src_rxrdy(src_rxrdy),
        .src_thre(src_thre), .src_modem(src_modem), .en_rdata(en_rdata_f),
        .id_rdata(id_rdata_f), .id_bit2(id_bit2_f), .irq(irq_f)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_en(input logic [7:0] v);
        en_wr = 1'b1; en_wdata = v;
        step();
        en_wr = 1'b0; en_wdata = 8'h00;
        step();
    endtask

    task automatic set_src(input logic l, input logic r, input logic t, input logic m);
        src_line = l; src_rxrdy = r; src_thre = t; src_modem = m;
        step();
    endtask

    task automatic t_reset();
        check("R1 id after reset", id_rdata, 8'h01);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        check("R1 enable after reset", en_rdata, 8'h00);
        check("R9 fixed mask after reset", en_rdata_f, 8'h04);
    endtask

    task automatic t_enable_write();
        write_en(8'hF5);
        check("R2 low bits stored, upper zero", en_rdata, 8'h05);
        write_en(8'hAA);
        check("R2 second write", en_rdata, 8'h0A);
        write_en(8'h05);
    endtask

    task automatic t_gating();
        // enables 0x05: receive data (bit0) and line status (bit2)
        set_src(0, 0, 1, 0);
        check("R3 masked thre gives none", id_rdata, 8'h01);
        check("R3 masked thre no irq", {7'b0, irq}, 8'h00);
        set_src(0, 0, 0, 1);
        check("R3 masked modem gives none", id_rdata, 8'h01);
        set_src(0, 1, 0, 0);
        check("R3 enabled rx data", id_rdata, 8'h04);
        check("R6 irq for rx data", {7'b0, irq}, 8'h01);
        set_src(0, 0, 0, 0);
    endtask

    task automatic t_priority();
        write_en(8'h0F);
        set_src(1, 1, 1, 1);
        check("R4 line status highest", id_rdata, 8'h06);
        check("R10 bit2 export high", {7'b0, id_bit2}, 8'h01);
        check("R9 fixed line pending", id_rdata_f, 8'h06);
        set_src(0, 1, 1, 1);
        check("R4 rx data next", id_rdata, 8'h04);
        check("R9 fixed ignores rx", id_rdata_f, 8'h01);
        set_src(0, 0, 1, 1);
        check("R4 thre next", id_rdata, 8'h02);
        check("R10 bit2 export low", {7'b0, id_bit2}, 8'h00);
        set_src(0, 0, 0, 1);
        check("R4 modem lowest", id_rdata, 8'h00);
        check("R6 irq for modem", {7'b0, irq}, 8'h01);
        set_src(0, 0, 0, 0);
        check("R5 none pending", id_rdata, 8'h01);
        check("R6 irq low when none", {7'b0, irq}, 8'h00);
        check("R7 upper id bits zero", id_rdata & 8'hF8, 8'h00);
        check("R9 fixed mask unchanged by writes", en_rdata_f, 8'h04);
    endtask

    task automatic t_hold();
        hold_id = 1'b1; src_line = 1'b1;
        step();
        check("R8 frozen during read", id_rdata, 8'h01);
        check("R8 irq frozen", {7'b0, irq}, 8'h00);
        step();
        check("R8 still frozen", id_rdata, 8'h01);
        hold_id = 1'b0;
        step();
        check("R8 resumes after read", id_rdata, 8'h06);
        check("R8 irq after resume", {7'b0, irq}, 8'h01);
        set_src(0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable_write();
        t_gating();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule